// File: doc/BRIEF.md
# Processor INIT pulse generator

This block produces the active-low processor initialization pulse of a PC-style chipset. Four trigger sources are combined into one request: a rising bit in the fast-reset register at I/O address 92h, a qualifying write to the reset-control register at I/O address CF9h, a falling edge on the keyboard-controller reset line, and a shutdown special-cycle strobe when the shutdown policy allows it. Any accepted trigger drives `init_n` low for a fixed number of clock cycles, 16 by default. The output then returns high.

A stop-clock input freezes the pulse timer. A trigger seen while stop-clock is asserted is held pending, and its pulse begins once stop-clock is released. Triggers that arrive while a pulse is pending or in progress are merged into that pulse and are not queued. When the shutdown policy bit is set, a shutdown cycle does not start a pulse. It raises a one-cycle full-reset request instead. Both port registers can be read back on a combinational read port that is selected by the I/O address.

Top module: `init_pulse_gen`

## Requirements
- R1: After reset, `init_n` is 1, `full_rst_req` is 0, both port registers read 00h, and the keyboard input is armed.
- R2: An accepted trigger drives `init_n` low for exactly PULSE_LEN (16) cycles in which `stop_clk` is 0, starting in the cycle after the triggering clock edge. `init_n` then returns to 1.
- R3: A write to address 0092h triggers a pulse only when stored bit 0 is 0 and written bit 0 is 1.
- R4: A write to address 0CF9h triggers a pulse only when stored bit 1 is 0, stored bit 2 is 0 and written bit 2 is 1.
- R5: The keyboard line `kbd_rst_n` passes through a two-flop synchronizer. A falling edge at its output triggers a pulse when the input is armed and `sleep_deep` is 0. The pulse starts on the third clock edge after the line falls.
- R6: A keyboard-triggered pulse disarms the keyboard input. The input is armed again only by a rising edge at the synchronizer output seen while `sleep_deep` is 0.
- R7: While `sleep_deep` is 1, keyboard edges neither trigger a pulse nor re-arm the input.
- R8: `shut_cyc` with `shut_policy` at 0 triggers a pulse. With `shut_policy` at 1, `full_rst_req` is 1 for exactly the following cycle and no pulse starts.
- R9: While `stop_clk` is 1, the low time does not advance and no new pulse starts. A trigger seen while `stop_clk` is 1 starts its pulse at the first edge at which `stop_clk` is 0.
- R10: Triggers that arrive while a pulse is pending or active are merged into it. They neither lengthen it nor cause a second pulse.
- R11: `io_rdata` returns the last value written to 0092h or 0CF9h when `io_addr` selects that address, and 00h for any other address. A write updates the register at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address for writes and readback |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rdata | output | 8 | Readback of the addressed port register |
| shut_cyc | input | 1 | Shutdown special-cycle strobe |
| shut_policy | input | 1 | Shutdown policy: 0 = INIT pulse, 1 = full-reset request |
| kbd_rst_n | input | 1 | Asynchronous active-low keyboard-controller reset line |
| stop_clk | input | 1 | Stop-clock: freezes the pulse timer |
| sleep_deep | input | 1 | System is in or is entering a deep sleep state |
| init_n | output | 1 | Active-low processor INIT pulse |
| full_rst_req | output | 1 | One-cycle full-reset request |

## Verification
Directed sequences test each trigger on its own. Port writes are applied both with and without the qualifying stored bits, which shows the edge-qualified triggers apart from plain level writes. Keyboard falls are applied with and without an intervening rise, and inside and outside deep sleep, which shows arming apart from sleep gating. Stop-clock is asserted before a trigger and also partway through a pulse, so the two can be told apart by the measured low length (16 and 21). Overlapping triggers show that pulses are merged rather than queued, and random mixed traffic is compared every cycle against a reference model in the bench.

// File: rtl/initpulse_pkg.sv
package initpulse_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam logic [ADDR_W-1:0] FAST_RST_ADDR = 16'h0092;
  localparam logic [ADDR_W-1:0] RST_CTL_ADDR  = 16'h0CF9;

  typedef enum logic [1:0] {
    TMR_IDLE = 2'd0,
    TMR_WAIT = 2'd1,
    TMR_LOW  = 2'd2
  } tmr_state_e;

  // Fast-reset port: bit 0 rising relative to stored value
  function automatic logic fast_rst_fires(input logic [DATA_W-1:0] held,
                                          input logic [DATA_W-1:0] wr);
    return (!held[0]) && wr[0];
  endfunction

  // Reset-control port: stored bit1 clear, bit2 rising
  function automatic logic rst_ctl_fires(input logic [DATA_W-1:0] held,
                                         input logic [DATA_W-1:0] wr);
    return (!held[1]) && (!held[2]) && wr[2];
  endfunction
endpackage

// File: rtl/init_port_regs.sv
module init_port_regs
  import initpulse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wr,
  output logic [DATA_W-1:0] io_rdata,
  output logic [DATA_W-1:0] fast_q,
  output logic [DATA_W-1:0] ctl_q,
  output logic              trig_fast,
  output logic              trig_ctl
);
  logic hit_fast, hit_ctl;

  assign hit_fast = io_wr && (io_addr == FAST_RST_ADDR);
  assign hit_ctl  = io_wr && (io_addr == RST_CTL_ADDR);

  assign trig_fast = hit_fast && fast_rst_fires(fast_q, io_wdata);
  assign trig_ctl  = hit_ctl  && rst_ctl_fires(ctl_q, io_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (hit_fast) fast_q <= io_wdata;
      if (hit_ctl)  ctl_q  <= io_wdata;
    end
  end

  always_comb begin
    if (io_addr == FAST_RST_ADDR)     io_rdata = fast_q;
    else if (io_addr == RST_CTL_ADDR) io_rdata = ctl_q;
    else                              io_rdata = '0;
  end
endmodule

// File: rtl/init_kbd_sense.sv
module init_kbd_sense #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kbd_rst_n,
  input  logic sleep_deep,
  output logic trig_kbd,
  output logic armed_o
);
  // stages 0..SYNC_STAGES-1 synchronize, the last one holds the previous value
  logic [SYNC_STAGES:0] shreg;
  logic fall_seen, rise_seen, armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) shreg <= '1;
    else        shreg <= {shreg[SYNC_STAGES-1:0], kbd_rst_n};
  end

  assign fall_seen = shreg[SYNC_STAGES] && !shreg[SYNC_STAGES-1];
  assign rise_seen = !shreg[SYNC_STAGES] && shreg[SYNC_STAGES-1];
  assign trig_kbd  = fall_seen && armed_q && !sleep_deep;

  always_ff @(posedge clk) begin
    if (!rst_n)                         armed_q <= 1'b1;
    else if (trig_kbd)                  armed_q <= 1'b0;
    else if (rise_seen && !sleep_deep)  armed_q <= 1'b1;
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/init_pulse_timer.sv
module init_pulse_timer
  import initpulse_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_any,
  input  logic stop_clk,
  output logic pulse_on,
  output logic pend_o
);
  localparam int unsigned CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_LEN - 1);

  tmr_state_e st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= TMR_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        TMR_IDLE: if (trig_any) begin
          cnt_q <= '0;
          st_q  <= stop_clk ? TMR_WAIT : TMR_LOW;
        end
        TMR_WAIT: if (!stop_clk) begin
          cnt_q <= '0;
          st_q  <= TMR_LOW;
        end
        TMR_LOW: if (!stop_clk) begin
          if (cnt_q == LAST) st_q <= TMR_IDLE;
          else               cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= TMR_IDLE;
      endcase
    end
  end

  assign pulse_on = (st_q == TMR_LOW);
  assign pend_o   = (st_q == TMR_WAIT);
endmodule

// File: rtl/init_pulse_gen.sv
module init_pulse_gen
  import initpulse_pkg::*;
#(
  parameter int unsigned PULSE_LEN   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wr,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              shut_cyc,
  input  logic              shut_policy,
  input  logic              kbd_rst_n,
  input  logic              stop_clk,
  input  logic              sleep_deep,
  output logic              init_n,
  output logic              full_rst_req
);
  logic [DATA_W-1:0] fast_q, ctl_q;
  logic trig_fast, trig_ctl, trig_kbd, trig_shut, trig_any;
  logic kbd_armed, pulse_on, pulse_pend;
  logic frr_q;

  init_port_regs u_regs (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rdata(io_rdata), .fast_q(fast_q), .ctl_q(ctl_q),
    .trig_fast(trig_fast), .trig_ctl(trig_ctl)
  );

  init_kbd_sense #(.SYNC_STAGES(SYNC_STAGES)) u_kbd (
    .clk(clk), .rst_n(rst_n), .kbd_rst_n(kbd_rst_n), .sleep_deep(sleep_deep),
    .trig_kbd(trig_kbd), .armed_o(kbd_armed)
  );

  assign trig_shut = shut_cyc && !shut_policy;
  assign trig_any  = trig_fast || trig_ctl || trig_kbd || trig_shut;

  init_pulse_timer #(.PULSE_LEN(PULSE_LEN)) u_tmr (
    .clk(clk), .rst_n(rst_n), .trig_any(trig_any), .stop_clk(stop_clk),
    .pulse_on(pulse_on), .pend_o(pulse_pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) frr_q <= 1'b0;
    else        frr_q <= shut_cyc && shut_policy;
  end

  assign init_n       = !pulse_on;
  assign full_rst_req = frr_q;
endmodule

// File: rtl/init_pulse_gen_chk.sv
module init_pulse_gen_chk
  import initpulse_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic [DATA_W-1:0] io_wdata,
  input logic [DATA_W-1:0] fast_q,
  input logic              shut_cyc,
  input logic              shut_policy,
  input logic              stop_clk,
  input logic              trig_any,
  input logic              pulse_pend,
  input logic              init_n,
  input logic              full_rst_req
);
  localparam int unsigned RW = $clog2(PULSE_LEN + 2) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n || init_n)  run_q <= '0;
    else if (!stop_clk)    run_q <= run_q + 1'b1;
  end

  // R2: completed pulse has exactly PULSE_LEN running cycles
  p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_n) |-> (run_q == RW'(PULSE_LEN)));

  // R2: idle trigger without stop-clock starts the pulse next cycle
  p_trig_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_any && init_n && !pulse_pend && !stop_clk) |=> !init_n);

  // R9: pulse frozen while stop-clock is high
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_clk && !init_n) |=> !init_n);

  // R9: no pulse may start while stop-clock is high
  p_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_clk && init_n) |=> init_n);

  // R8: policy 1 shutdown yields a single-cycle request
  p_frr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_cyc && shut_policy) |=> full_rst_req);

  p_frr_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_rst_req) |-> $past(shut_cyc && shut_policy));

  // R11: fast-reset register captures written data
  p_fast_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == FAST_RST_ADDR) |=> (fast_q == $past(io_wdata)));
endmodule

bind init_pulse_gen init_pulse_gen_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
  .io_wdata(io_wdata), .fast_q(fast_q), .shut_cyc(shut_cyc),
  .shut_policy(shut_policy), .stop_clk(stop_clk), .trig_any(trig_any),
  .pulse_pend(pulse_pend), .init_n(init_n), .full_rst_req(full_rst_req)
);

// File: tb/init_pulse_gen_test.sv
module init_pulse_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic [7:0]  io_wdata = 8'h00;
  logic        io_wr = 1'b0;
  logic [7:0]  io_rdata;
  logic        shut_cyc = 1'b0, shut_policy = 1'b0;
  logic        kbd_rst_n = 1'b1, stop_clk = 1'b0, sleep_deep = 1'b0;
  logic        init_n, full_rst_req;

  int n_chk = 0, n_fail = 0;
  int run = 0, last_run = 0, npulse = 0;
  bit cmp_on = 1'b0;

  init_pulse_gen uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rdata(io_rdata), .shut_cyc(shut_cyc),
    .shut_policy(shut_policy), .kbd_rst_n(kbd_rst_n), .stop_clk(stop_clk),
    .sleep_deep(sleep_deep), .init_n(init_n), .full_rst_req(full_rst_req)
  );

  always #10 clk = ~clk;

  // ---------------- reference model, from the requirements ----------------
  function automatic bit exp_fast(input logic [7:0] old, input logic [7:0] nw);
    return old[0] == 1'b0 && nw[0] == 1'b1;
  endfunction
  function automatic bit exp_ctl(input logic [7:0] old, input logic [7:0] nw);
    return old[1] == 1'b0 && old[2] == 1'b0 && nw[2] == 1'b1;
  endfunction

  logic [7:0] m92 = 0, mcf9 = 0;
  logic m_k1 = 1, m_k2 = 1, m_k3 = 1, m_arm = 1, m_pend = 0, m_frr = 0;
  int   m_left = 0;

  always @(posedge clk) begin
    bit t, kf;
    if (!rst_n) begin
      m92 <= 0; mcf9 <= 0; m_k1 <= 1; m_k2 <= 1; m_k3 <= 1; m_arm <= 1;
      m_pend <= 0; m_frr <= 0; m_left <= 0;
    end else begin
      kf = m_k3 && !m_k2 && m_arm && !sleep_deep;
      t = kf || (shut_cyc && !shut_policy);
      if (io_wr && io_addr == 16'h0092) begin t |= exp_fast(m92, io_wdata); m92 <= io_wdata; end
      if (io_wr && io_addr == 16'h0CF9) begin t |= exp_ctl(mcf9, io_wdata); mcf9 <= io_wdata; end
      if (kf) m_arm <= 0;
      else if (!m_k3 && m_k2 && !sleep_deep) m_arm <= 1;
      m_k1 <= kbd_rst_n; m_k2 <= m_k1; m_k3 <= m_k2;
      m_frr <= shut_cyc && shut_policy;
      if (m_left == 0) begin
        if ((t || m_pend) && !stop_clk) begin m_left <= 16; m_pend <= 0; end
        else if (t) m_pend <= 1;
      end else if (!stop_clk) m_left <= m_left - 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // sample mid high phase
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      if (!init_n) run++;
      else if (run > 0) begin last_run = run; run = 0; npulse++; end
      if (cmp_on) begin
        logic [7:0] er;
        er = (io_addr == 16'h0092) ? m92 : (io_addr == 16'h0CF9) ? mcf9 : 8'h00;
        check(init_n == (m_left == 0), "R2 model init_n", init_n, m_left == 0);
        check(full_rst_req == m_frr, "R8 model full_rst_req", full_rst_req, m_frr);
        check(io_rdata == er, "R11 model readback", io_rdata, er);
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  task automatic wr_io(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int p0;

  initial begin
    idle(3); rst_n = 1'b1;
    @(posedge clk); #5;
    // R1 reset state
    check(init_n === 1'b1, "R1 init_n high", init_n, 1);
    check(full_rst_req === 1'b0, "R1 full_rst_req low", full_rst_req, 0);
    io_addr = 16'h0092; #1;
    check(io_rdata == 8'h00, "R1 port92 cleared", io_rdata, 0);
    io_addr = 16'h0CF9; #1;
    check(io_rdata == 8'h00, "R1 portCF9 cleared", io_rdata, 0);
    cmp_on = 1'b1;

    // R3 + R2: bit0 rising
    p0 = npulse; wr_io(16'h0092, 8'h01); idle(25);
    check(npulse == p0 + 1, "R3 fast-reset rise pulses", npulse - p0, 1);
    check(last_run == 16, "R2 pulse length", last_run, 16);
    p0 = npulse; wr_io(16'h0092, 8'h03); idle(25);
    check(npulse == p0, "R3 bit0 already set no pulse", npulse - p0, 0);
    io_addr = 16'h0092; #1;
    check(io_rdata == 8'h03, "R11 port92 readback", io_rdata, 3);

    // R4
    p0 = npulse; wr_io(16'h0CF9, 8'h04); idle(25);
    check(npulse == p0 + 1, "R4 reset-control pulses", npulse - p0, 1);
    p0 = npulse; wr_io(16'h0CF9, 8'h02); wr_io(16'h0CF9, 8'h06); idle(25);
    check(npulse == p0, "R4 stored bit1 blocks", npulse - p0, 0);
    io_addr = 16'h0CF9; #1;
    check(io_rdata == 8'h06, "R11 portCF9 readback", io_rdata, 6);
    wr_io(16'h0CF9, 8'h00);

    // R5 keyboard fall, latency of three edges
    @(negedge clk); kbd_rst_n = 1'b0;
    @(posedge clk); #5; @(posedge clk); #5;
    check(init_n == 1'b1, "R5 still synchronizing", init_n, 1);
    @(posedge clk); #5;
    check(init_n == 1'b0, "R5 pulse after sync", init_n, 0);
    idle(25);
    // R6 rearm by rise
    p0 = npulse; kbd_rst_n = 1'b1; idle(4); kbd_rst_n = 1'b0; idle(25);
    check(npulse == p0 + 1, "R6 rearmed by rise", npulse - p0, 1);
    // R7/R6 rise during sleep does not rearm
    p0 = npulse; sleep_deep = 1'b1; kbd_rst_n = 1'b1; idle(4); sleep_deep = 1'b0;
    idle(2); kbd_rst_n = 1'b0; idle(25);
    check(npulse == p0, "R6 rise in sleep leaves disarmed", npulse - p0, 0);
    kbd_rst_n = 1'b1; idle(4); sleep_deep = 1'b1; kbd_rst_n = 1'b0; idle(5);
    sleep_deep = 1'b0; idle(20);
    check(npulse == p0, "R7 fall in sleep ignored", npulse - p0, 0);
    kbd_rst_n = 1'b1; idle(5);

    // R8
    p0 = npulse; shut_cyc = 1'b1; shut_policy = 1'b0; idle(1); shut_cyc = 1'b0; idle(25);
    check(npulse == p0 + 1, "R8 policy0 pulses", npulse - p0, 1);
    p0 = npulse; shut_cyc = 1'b1; shut_policy = 1'b1; @(negedge clk); shut_cyc = 1'b0;
    #5; check(full_rst_req == 1'b1, "R8 full reset request", full_rst_req, 1);
    @(negedge clk); #5;
    check(full_rst_req == 1'b0, "R8 request one cycle", full_rst_req, 0);
    idle(25);
    check(npulse == p0, "R8 policy1 no pulse", npulse - p0, 0);
    shut_policy = 1'b0;

    // R9 trigger during stop-clock
    wr_io(16'h0092, 8'h00);
    p0 = npulse; stop_clk = 1'b1; wr_io(16'h0092, 8'h01); idle(8);
    check(init_n == 1'b1, "R9 held while stopped", init_n, 1);
    stop_clk = 1'b0; idle(25);
    check(npulse == p0 + 1 && last_run == 16, "R9 pending pulse length", last_run, 16);
    // R9 freeze mid-pulse
    wr_io(16'h0092, 8'h00); wr_io(16'h0092, 8'h01); idle(3);
    stop_clk = 1'b1; idle(5); stop_clk = 1'b0; idle(30);
    check(last_run == 21, "R9 frozen pulse length", last_run, 21);

    // R10 merge
    wr_io(16'h0092, 8'h00);
    p0 = npulse; wr_io(16'h0092, 8'h01); idle(3);
    shut_cyc = 1'b1; idle(1); shut_cyc = 1'b0; wr_io(16'h0CF9, 8'h04); idle(30);
    check(npulse == p0 + 1 && last_run == 16, "R10 merged pulse", npulse - p0, 1);
    wr_io(16'h0CF9, 8'h00);

    // random mixed traffic, checked against the model every cycle
    void'($urandom(32'd4711));
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      io_wr = ($urandom % 4) == 0;
      case ($urandom % 3)
        0: io_addr = 16'h0092;
        1: io_addr = 16'h0CF9;
        default: io_addr = 16'($urandom);
      endcase
      io_wdata = 8'($urandom);
      shut_cyc = ($urandom % 16) == 0;
      shut_policy = 1'($urandom);
      if (($urandom % 10) == 0) kbd_rst_n = ~kbd_rst_n;
      if (($urandom % 8) == 0) stop_clk = ~stop_clk;
      if (($urandom % 20) == 0) sleep_deep = ~sleep_deep;
    end
    @(negedge clk);
    io_wr = 0; shut_cyc = 0; stop_clk = 0;
    idle(40);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule